// File: doc/BRIEF.md
# Condition Pass Unit with Deferred Flags

This block decides whether a conditional instruction executes. It does not read a stored flag word. It takes a packed 8-bit selector and three data words that describe the last flag-setting operation. From these it rebuilds the N, Z, C and V flags, then tests them against the requested condition, all in one combinational path.

The selector carries the condition code in its upper nibble and the operation tag in its lower nibble. Conditions come in pairs that share a base test, and the low bit of the condition code inverts that test. The always condition passes without looking at the flag record. The never condition fails and raises a flag. An unknown operation tag is reported on its own output, except under the always condition, where it is masked.

Top module: `cond_check`

## Requirements
- R1: The condition code is `sel_i[7:4]` and the operation tag is `sel_i[3:0]`. The tag values are:

  | Tag | Operation | Record words (w1, w2, w3) |
  |-----|-----------|---------------------------|
  | 0 | copy | flag word, unused, unused |
  | 1 | add | a, b, unused |
  | 2 | sub | a, b, unused |
  | 3 | add-with-carry | a, b, carry in `w3[0]` |
  | 4 | sub-with-borrow | a, b, carry in `w3[0]` |
  | 5 | logic | result, shifter carry `w2[0]`, old V `w3[0]` |
  | 6 | mul | result, unused, {old C `w3[1]`, old V `w3[0]`} |
  | 7 | long mul | low half, high half, {old C `w3[1]`, old V `w3[0]`} |

  Tags 8 to 15 are illegal.
- R2: Condition 14 (always) gives `pass_o`=1 and `illegal_op_o`=0 for any tag, including an illegal one.
- R3: Condition 15 (never) gives `pass_o`=0 and `illegal_cond_o`=1. Every other condition gives `illegal_cond_o`=0.
- R4: For conditions 0 to 13 and a fixed record, an odd condition gives the inverse of the even condition just below it.
- R5: The even conditions test these expressions:
  - 0 tests Z.
  - 2 tests C.
  - 4 tests N.
  - 6 tests V.
  - 8 tests C and not Z.
  - 10 tests N equal to V.
  - 12 tests not Z and N equal to V.
- R6: For add and add-with-carry, the result is w1+w2+cin with cin=0 for add. N is result bit 31, Z means the result is zero, C is the unsigned carry out, and V is signed overflow.
- R7: For sub and sub-with-borrow, the result is w1-w2-(1-cin) with cin=1 for sub. C=1 means no borrow (for sub: w1>=w2 unsigned), and V is signed overflow.
- R8: For copy, N, Z, C and V are w1 bits 31, 30, 29 and 28.
- R9: For logic and mul, N and Z come from w1. For long mul, N is w2 bit 31 and Z means both w1 and w2 are zero. C and V come from w2[0] and w3[0] for logic, and from w3[1] and w3[0] for the two multiplies.
- R10: An illegal tag sets `illegal_op_o` unless the condition is 14, and all four flags read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 8 | {condition, operation tag} |
| rec_w1_i | input | 32 | Flag record word 1 |
| rec_w2_i | input | 32 | Flag record word 2 |
| rec_w3_i | input | 32 | Flag record word 3 |
| pass_o | output | 1 | Instruction executes |
| illegal_cond_o | output | 1 | Never condition selected |
| illegal_op_o | output | 1 | Unknown tag, masked under always |

## Verification
Immediate assertions watch every evaluation. They check the always and never outcomes, that the illegal-condition output is exclusive to condition 15, that an illegal tag yields all-zero flags, that the carry for add and sub is correct, and that the equal test follows Z. Other behaviour can only be shown by the bench's scenarios:
- the pairwise inversion, which needs two evaluations of one record;
- signed overflow at the boundaries;
- the carry-in corner cases of add-with-carry and sub-with-borrow;
- the long-multiply zero test across both halves.

// File: rtl/cond_flag_pkg.sv
package cond_flag_pkg;

  typedef enum logic [3:0] {
    TAG_COPY  = 4'd0,
    TAG_ADD   = 4'd1,
    TAG_SUB   = 4'd2,
    TAG_ADC   = 4'd3,
    TAG_SBB   = 4'd4,
    TAG_LOGIC = 4'd5,
    TAG_MUL   = 4'd6,
    TAG_MULL  = 4'd7
  } rec_tag_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/flag_rec_eval.sv
module flag_rec_eval
  import cond_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   tag_i,
  input  logic [W-1:0] w1_i,
  input  logic [W-1:0] w2_i,
  input  logic [W-1:0] w3_i,
  output flags_t       flags_o,
  output logic         illegal_o
);

  localparam int POS_N = W - 1;
  localparam int POS_Z = W - 2;
  localparam int POS_C = W - 3;
  localparam int POS_V = W - 4;

  logic         is_sub;
  logic         cin;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [W-1:0] res;
  logic         ovf;
  logic         unused_w3;

  assign unused_w3 = ^w3_i[W-1:2];

  // one shared adder: subtract as a + ~b + cin
  always_comb begin
    is_sub = (tag_i == TAG_SUB) || (tag_i == TAG_SBB);
    unique case (tag_i)
      TAG_SUB:          cin = 1'b1;
      TAG_ADC, TAG_SBB: cin = w3_i[0];
      default:          cin = 1'b0;
    endcase
    b_eff = is_sub ? ~w2_i : w2_i;
    sum   = {1'b0, w1_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    res   = sum[W-1:0];
    ovf   = ~(w1_i[W-1] ^ b_eff[W-1]) & (w1_i[W-1] ^ res[W-1]);
  end

  always_comb begin
    flags_o   = '0;
    illegal_o = 1'b0;
    unique case (tag_i)
      TAG_COPY: begin
        flags_o.n = w1_i[POS_N];
        flags_o.z = w1_i[POS_Z];
        flags_o.c = w1_i[POS_C];
        flags_o.v = w1_i[POS_V];
      end
      TAG_ADD, TAG_SUB, TAG_ADC, TAG_SBB: begin
        flags_o.n = res[W-1];
        flags_o.z = (res == '0);
        flags_o.c = sum[W];
        flags_o.v = ovf;
      end
      TAG_LOGIC: begin
        flags_o.n = w1_i[W-1];
        flags_o.z = (w1_i == '0);
        flags_o.c = w2_i[0];
        flags_o.v = w3_i[0];
      end
      TAG_MUL: begin
        flags_o.n = w1_i[W-1];
        flags_o.z = (w1_i == '0);
        flags_o.c = w3_i[1];
        flags_o.v = w3_i[0];
      end
      TAG_MULL: begin
        flags_o.n = w2_i[W-1];
        flags_o.z = ((w1_i | w2_i) == '0);
        flags_o.c = w3_i[1];
        flags_o.v = w3_i[0];
      end
      default: illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown({tag_i, w1_i, w2_i, w3_i})) begin
      AST_ILLEGAL_FLAGS_ZERO: assert (!illegal_o || flags_o == '0) else $error("illegal tag flags"); // R10
      AST_SUB_CARRY: assert (tag_i != TAG_SUB || flags_o.c == (w1_i >= w2_i)) else $error("sub carry"); // R7
      AST_ADD_CARRY: assert (tag_i != TAG_ADD || flags_o.c == (W'(w1_i + w2_i) < w1_i)) else $error("add carry"); // R6
    end
  end

endmodule

// File: rtl/cond_decode.sv
module cond_decode
  import cond_flag_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o,
  output logic       illegal_cond_o
);

  logic base;
  logic n_eq_v;

  assign n_eq_v = ~(flags_i.n ^ flags_i.v);

  // pairs share cond_i[3:1]; cond_i[0] inverts
  always_comb begin
    unique case (cond_i[3:1])
      3'd0:    base = flags_i.z;
      3'd1:    base = flags_i.c;
      3'd2:    base = flags_i.n;
      3'd3:    base = flags_i.v;
      3'd4:    base = flags_i.c & ~flags_i.z;
      3'd5:    base = n_eq_v;
      3'd6:    base = ~flags_i.z & n_eq_v;
      default: base = 1'b1;
    endcase
  end

  always_comb begin
    illegal_cond_o = (cond_i == CC_NV);
    if (cond_i == CC_AL)      pass_o = 1'b1;
    else if (cond_i == CC_NV) pass_o = 1'b0;
    else                      pass_o = base ^ cond_i[0];
  end

  always_comb begin
    if (!$isunknown({cond_i, flags_i})) begin
      AST_EQ_FOLLOWS_Z: assert (cond_i != CC_EQ || pass_o == flags_i.z) else $error("EQ vs Z"); // R5
      AST_HI_TEST: assert (cond_i != CC_HI || pass_o == (flags_i.c && !flags_i.z)) else $error("HI test"); // R5
    end
  end

endmodule

// File: rtl/cond_check.sv
module cond_check
  import cond_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [7:0]   sel_i,
  input  logic [W-1:0] rec_w1_i,
  input  logic [W-1:0] rec_w2_i,
  input  logic [W-1:0] rec_w3_i,
  output logic         pass_o,
  output logic         illegal_cond_o,
  output logic         illegal_op_o
);

  logic [3:0] cond;
  logic [3:0] tag;
  flags_t     flags;
  logic       ill_op_raw;

  assign cond = sel_i[7:4];
  assign tag  = sel_i[3:0];

  flag_rec_eval #(.W(W)) u_eval (
    .tag_i     (tag),
    .w1_i      (rec_w1_i),
    .w2_i      (rec_w2_i),
    .w3_i      (rec_w3_i),
    .flags_o   (flags),
    .illegal_o (ill_op_raw)
  );

  cond_decode u_dec (
    .cond_i         (cond),
    .flags_i        (flags),
    .pass_o         (pass_o),
    .illegal_cond_o (illegal_cond_o)
  );

  assign illegal_op_o = ill_op_raw & (cond != CC_AL);

  always_comb begin
    if (!$isunknown(sel_i)) begin
      AST_ALWAYS_PASSES: assert (sel_i[7:4] != 4'd14 || (pass_o && !illegal_op_o)) else $error("always cond"); // R2
      AST_NEVER_FAILS: assert (sel_i[7:4] != 4'd15 || (!pass_o && illegal_cond_o)) else $error("never cond"); // R3
      AST_ILL_COND_ONLY_NV: assert (!illegal_cond_o || sel_i[7:4] == 4'd15) else $error("illegal cond"); // R3
    end
  end

endmodule

// File: tb/cond_check_tb.sv
module cond_check_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sel = '0;
  logic [31:0] w1 = '0, w2 = '0, w3 = '0;
  logic        pass, ill_cond, ill_op;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  cond_check u_dut (
    .sel_i(sel), .rec_w1_i(w1), .rec_w2_i(w2), .rec_w3_i(w3),
    .pass_o(pass), .illegal_cond_o(ill_cond), .illegal_op_o(ill_op)
  );

  // behavioural flag model, returns {n,z,c,v}; tag > 7 gives 0
  function automatic logic [3:0] ref_flags(input int tag, input logic [31:0] a,
                                           input logic [31:0] b, input logic [31:0] x);
    logic [31:0] r;
    logic n, z, c, v;
    n = 0; z = 0; c = 0; v = 0;
    case (tag)
      0: begin n = a[31]; z = a[30]; c = a[29]; v = a[28]; end
      1: begin r = a + b; n = r[31]; z = (r == 0); c = (r < a);
               v = ((r ^ a) & (r ^ b)) >> 31; end
      2: begin r = a - b; n = r[31]; z = (r == 0); c = (a >= b);
               v = ((a ^ b) & (a ^ r)) >> 31; end
      3: begin r = a + b + {31'd0, x[0]}; n = r[31]; z = (r == 0);
               c = x[0] ? (r <= a) : (r < a);
               v = ((r ^ a) & (r ^ b)) >> 31; end
      4: begin r = a - b - {31'd0, ~x[0]}; n = r[31]; z = (r == 0);
               c = x[0] ? (a >= b) : (a > b);
               v = ((a ^ b) & (a ^ r)) >> 31; end
      5: begin n = a[31]; z = (a == 0); c = b[0]; v = x[0]; end
      6: begin n = a[31]; z = (a == 0); c = x[1]; v = x[0]; end
      7: begin n = b[31]; z = ((a | b) == 0); c = x[1]; v = x[0]; end
      default: ;
    endcase
    return {n, z, c, v};
  endfunction

  function automatic logic ref_pass(input int cond, input logic [3:0] f);
    logic b;
    if (cond == 14) return 1'b1;
    if (cond == 15) return 1'b0;
    case (cond / 2)
      0: b = f[2];
      1: b = f[1];
      2: b = f[3];
      3: b = f[0];
      4: b = f[1] & ~f[2];
      5: b = (f[3] == f[0]);
      default: b = ~f[2] & (f[3] == f[0]);
    endcase
    return b ^ cond[0];
  endfunction

  function automatic string req_of(input int cond, input int tag);
    if (cond == 14) return "R2";
    if (cond == 15) return "R3";
    if (tag > 7) return "R10";
    if (tag == 0) return "R1 R5 R8";
    if (tag == 1 || tag == 3) return "R1 R5 R6";
    if (tag == 2 || tag == 4) return "R1 R5 R7";
    return "R1 R5 R9";
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%02h w1=%08h w2=%08h w3=%08h act{pass,ic,io}=%b exp=%b",
               req, sel, w1, w2, w3, act, exp);
    end
  endtask

  // all 16 conditions on one record, plus the pair inversion check
  task automatic sweep(input int tag, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] x);
    logic [3:0] f;
    logic prev;
    f = ref_flags(tag, a, b, x);
    prev = 1'b0;
    for (int cc = 0; cc < 16; cc++) begin
      @(posedge clk);
      sel = {cc[3:0], tag[3:0]}; w1 = a; w2 = b; w3 = x;
      @(negedge clk);
      check(req_of(cc, tag), {pass, ill_cond, ill_op},
            {ref_pass(cc, f), cc == 15, (tag > 7) && (cc != 14)});
      if (cc < 14 && cc[0]) check("R4", {2'b00, pass}, {2'b00, ~prev});
      prev = pass;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle: EQ on copy of zero word
    check("R1 R8", {pass, ill_cond, ill_op}, 3'b000);
    sweep(0, 32'hF000_0000, 0, 0);                  // R8 all flags set
    sweep(0, 32'h5000_0000, 0, 0);                  // R8 Z,V
    sweep(0, 32'hA000_0000, 0, 0);                  // R8 N,C
    sweep(1, 32'h7FFF_FFFF, 32'h1, 0);              // R6 overflow
    sweep(1, 32'hFFFF_FFFF, 32'h1, 0);              // R6 carry, zero
    sweep(1, 32'h8000_0000, 32'h8000_0000, 0);      // R6 carry+overflow
    sweep(2, 32'h1234, 32'h1234, 0);                // R7 equal
    sweep(2, 32'h1, 32'h2, 0);                      // R7 borrow
    sweep(2, 32'h8000_0000, 32'h1, 0);              // R7 overflow
    sweep(3, 32'hFFFF_FFFF, 32'h0, 32'h1);          // R6 carry-in wraps
    sweep(3, 32'h7FFF_FFFE, 32'h1, 32'h1);          // R6 overflow via cin
    sweep(4, 32'h5, 32'h5, 32'h0);                  // R7 borrow in, equal
    sweep(4, 32'h5, 32'h5, 32'h1);                  // R7 no borrow, zero
    sweep(5, 32'h0, 32'h1, 32'h1);                  // R9 logic
    sweep(6, 32'h8000_0000, 0, 32'h2);              // R9 mul
    sweep(7, 32'h0, 32'h0, 32'h3);                  // R9 long mul zero
    sweep(7, 32'h1, 32'h0, 32'h0);                  // R9 long mul nonzero low
    sweep(7, 32'h0, 32'h8000_0000, 32'h1);          // R9 negative high
    sweep(8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h3);  // R10
    sweep(15, 32'h0, 32'h0, 32'h0);                 // R10
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb, rx;
      seed = seed * 32'd1103515245 + 32'd12345; ra = seed;
      seed = seed * 32'd1103515245 + 32'd12345; rb = (seed[3:0] == 0) ? ra : seed;
      seed = seed * 32'd1103515245 + 32'd12345; rx = {30'd0, seed[17:16]};
      sweep(int'(seed[27:24]), ra, rb, rx);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule